// File: doc/BRIEF.md
# SMBus Packet Error Code Sequencer

This block sits beside a byte-level shift engine in an SMBus controller. It counts the data bytes of a transfer against a programmed length, keeps a running CRC-8 over every byte on the wire, and decides whether the final counted slot carries the packet error code. In transmit it offers the CRC as the byte to send in that slot. In receive it compares the incoming code with its own CRC and flags a mismatch.

The engine pulses `start_evt` on each START or repeated START. It pulses `byte_done` once per completed byte, with the byte value and a flag that marks address bytes. The sequencer raises `pec_next` while the next data byte is the error-code slot. It pulses `xfer_done` once the programmed count has been used up. The engine can then close with a STOP or a repeated START.

The sequencer has four named states:
- `ST_IDLE`: the peripheral is off, or no START has been seen since it was enabled.
- `ST_DATA`: ordinary data bytes are being counted.
- `ST_PEC`: the next data byte is the error-code slot.
- `ST_DONE`: the count is exhausted.

It takes these transitions:
- Any state goes to `ST_IDLE` when `periph_en` falls.
- A START while enabled goes to `ST_DONE` if the count is zero, to `ST_PEC` if the slot is armed and the count is one, and to `ST_DATA` otherwise.
- `ST_DATA` goes to `ST_DONE` on the last counted byte, and to `ST_PEC` when the slot is armed and two bytes remain.
- `ST_PEC` goes to `ST_DONE` on its byte.
- `ST_DONE` leaves only on a new START or on disable.

Top module: `smbus_pec_seq`

## Requirements
- R1: After reset, `pec_next`, `pec_err` and `xfer_done` are 0, `pec_en` is 0, and `tx_pec_data` is 0x00.
- R2: A write through `cfg_wr` loads `cfg_pec_en` into `pec_en` only while `periph_en` is 0. While `periph_en` is 1, the write leaves `pec_en` unchanged.
- R3: The CRC uses polynomial 0x07 (x^8+x^2+x+1), starts at 0x00, and takes each byte MSB first. Every byte strobed during a transfer updates it, address bytes included. Its current value is always on `tx_pec_data`, one cycle after the strobe.
- R4: A `start_evt` while `periph_en` is 1 clears the CRC to 0x00 and reloads the remaining count from `nbytes`.
- R5: The slot is armed when all of these hold at the START: `pec_en` is 1, `pec_byte_req` is 1, `reload` is 0, and either `slave_mode` is 0 or `byte_cnt_en` is 1. When armed, `pec_next` is 1 after exactly `nbytes`−1 data bytes and falls after the next data byte.
- R6: With `reload` set at the START, `pec_byte_req` has no effect and `pec_next` never rises in that transfer.
- R7: With `slave_mode` set and `byte_cnt_en` clear at the START, no slot is produced.
- R8: In the slot with `dir_rx`=1, a received byte that differs from the CRC makes `pec_err` 1 for exactly the one cycle after the strobe. A matching byte, a transmit slot, or a non-slot byte leaves `pec_err` at 0.
- R9: Bytes with `byte_is_addr`=1 are not counted. `xfer_done` pulses for one cycle after the `nbytes`-th data byte, and is 0 after every other byte.
- R10: With `periph_en` low the sequencer returns to idle. Until the next START, strobed bytes change neither the CRC nor `pec_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable |
| cfg_wr | input | 1 | Write strobe for the PEC enable |
| cfg_pec_en | input | 1 | Value written to the PEC enable |
| pec_en | output | 1 | Current PEC enable |
| nbytes | input | 8 | Programmed data byte count |
| pec_byte_req | input | 1 | Request an error-code byte in the last slot |
| reload | input | 1 | Reload mode; suppresses the slot |
| slave_mode | input | 1 | 1 when acting as target |
| byte_cnt_en | input | 1 | Byte counting enabled in target mode |
| dir_rx | input | 1 | 1 when receiving |
| start_evt | input | 1 | START or repeated START pulse |
| byte_done | input | 1 | One byte completed |
| byte_is_addr | input | 1 | Completed byte was an address byte |
| byte_data | input | 8 | Value of the completed byte |
| pec_next | output | 1 | Next data byte is the error-code slot |
| tx_pec_data | output | 8 | Current CRC, sent as the slot byte in transmit |
| pec_err | output | 1 | One-cycle pulse on a received code mismatch |
| xfer_done | output | 1 | One-cycle pulse after the last counted byte |

## Verification
The outputs expose a wrong internal state quickly.

A corrupted CRC register appears on `tx_pec_data` in the cycle after the byte that caused it. A stale CRC left over from the previous transfer shows as a nonzero value right after a START.

A counter that is off by one, or a slot armed under the wrong conditions, moves `pec_next` to the wrong byte within the same transfer. It also moves the `xfer_done` pulse.

A slip in the comparison path shows up as `pec_err` missing on a corrupted received code, or firing on a correct one. This is visible one cycle after the slot byte.

// File: rtl/pec_seq_pkg.sv
package pec_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PEC  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    // One byte through a CRC-8, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ data[i];
            c  = {c[6:0], 1'b0} ^ (fb ? poly : 8'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/pec_cfg_lock.sv
module pec_cfg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic periph_en,
    input  logic cfg_wr,
    input  logic cfg_pec_en,
    output logic pec_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pec_en <= 1'b0;
        else if (cfg_wr && !periph_en)
            pec_en <= cfg_pec_en;
    end

    // R2: enable frozen while the peripheral runs
    a_r2_locked_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |=> $stable(pec_en));

endmodule

// File: rtl/pec_crc8.sv
module pec_crc8 #(
    parameter int         W    = 8,
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc
);
    import pec_seq_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (upd)
            crc <= crc8_step(crc, din, POLY);
    end

    // R3: no strobe, no change
    a_r3_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(crc));
    // R4: clear lands as zero
    a_r4_crc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0));

endmodule

// File: rtl/pec_byte_counter.sv
module pec_byte_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remain
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec && remain != '0)
            remain <= remain - 1'b1;
    end

    // R9: data strobes only arrive while bytes remain
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (remain != '0));

endmodule

// File: rtl/smbus_pec_seq.sv
module smbus_pec_seq #(
    parameter int CNT_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              cfg_wr,
    input  logic              cfg_pec_en,
    output logic              pec_en,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              pec_byte_req,
    input  logic              reload,
    input  logic              slave_mode,
    input  logic              byte_cnt_en,
    input  logic              dir_rx,
    input  logic              start_evt,
    input  logic              byte_done,
    input  logic              byte_is_addr,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              pec_next,
    output logic [BYTE_W-1:0] tx_pec_data,
    output logic              pec_err,
    output logic              xfer_done
);
    import pec_seq_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    seq_state_t         state_q, state_d;
    logic               armed_q, armed_d;
    logic               start_go, in_xfer, data_stb, crc_upd, last_byte;
    logic [CNT_W-1:0]   remain;
    logic [BYTE_W-1:0]  crc_q;

    assign start_go  = start_evt && periph_en;
    assign in_xfer   = (state_q != ST_IDLE) && periph_en;
    assign data_stb  = byte_done && !byte_is_addr && !start_evt && periph_en &&
                       ((state_q == ST_DATA) || (state_q == ST_PEC));
    assign crc_upd   = byte_done && !start_evt && in_xfer;
    assign last_byte = (remain == ONE);
    assign armed_d   = pec_en && pec_byte_req && !reload && (!slave_mode || byte_cnt_en);

    pec_cfg_lock u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .periph_en  (periph_en),
        .cfg_wr     (cfg_wr),
        .cfg_pec_en (cfg_pec_en),
        .pec_en     (pec_en)
    );

    pec_crc8 #(.W(BYTE_W), .POLY(8'h07)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_go),
        .upd   (crc_upd),
        .din   (byte_data),
        .crc   (crc_q)
    );

    pec_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_go),
        .load_val (nbytes),
        .dec      (data_stb),
        .remain   (remain)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!periph_en) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            if (nbytes == '0)
                state_d = ST_DONE;
            else if (armed_d && nbytes == ONE)
                state_d = ST_PEC;
            else
                state_d = ST_DATA;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_DATA: begin
                    if (data_stb) begin
                        if (last_byte)
                            state_d = ST_DONE;
                        else if (armed_q && remain == TWO)
                            state_d = ST_PEC;
                    end
                end
                ST_PEC:  if (data_stb) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_go)
                armed_q <= armed_d;
        end
    end

    // Registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pec_err   <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            pec_err   <= data_stb && (state_q == ST_PEC) && dir_rx && (byte_data != crc_q);
            xfer_done <= data_stb && last_byte;
        end
    end

    assign pec_next    = (state_q == ST_PEC);
    assign tx_pec_data = crc_q;

    // R5: slot only on the final counted byte
    a_r5_slot_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        pec_next |-> (remain == ONE));
    // R6: reload at START keeps the slot away
    a_r6_reload_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (start_go && reload) |=> !pec_next);
    // R7: target without byte counting has no slot
    a_r7_slave_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start_go && slave_mode && !byte_cnt_en) |=> !pec_next);
    // R8: error only after a received slot byte
    a_r8_err_rx_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pec_err |-> ($past(dir_rx) && $past(state_q == ST_PEC)));
    // R8: single-cycle pulse
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pec_err |=> !pec_err);
    // R9: done pulse is single-cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
    // R10: disabled means idle
    a_r10_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (state_q == ST_IDLE));

endmodule

// File: tb/tb_smbus_pec_seq.sv
module tb_smbus_pec_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_en = 1'b0, cfg_wr = 1'b0, cfg_pec_en = 1'b0;
    logic       pec_en;
    logic [7:0] nbytes = 8'd0;
    logic       pec_byte_req = 1'b0, reload = 1'b0, slave_mode = 1'b0, byte_cnt_en = 1'b0;
    logic       dir_rx = 1'b0, start_evt = 1'b0, byte_done = 1'b0, byte_is_addr = 1'b0;
    logic [7:0] byte_data = 8'd0;
    logic       pec_next, pec_err, xfer_done;
    logic [7:0] tx_pec_data;

    int total = 0;
    int bad = 0;
    logic [7:0] gcrc;

    always #2.5 clk = ~clk;

    smbus_pec_seq dut (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .cfg_wr(cfg_wr),
        .cfg_pec_en(cfg_pec_en), .pec_en(pec_en), .nbytes(nbytes),
        .pec_byte_req(pec_byte_req), .reload(reload), .slave_mode(slave_mode),
        .byte_cnt_en(byte_cnt_en), .dir_rx(dir_rx), .start_evt(start_evt),
        .byte_done(byte_done), .byte_is_addr(byte_is_addr), .byte_data(byte_data),
        .pec_next(pec_next), .tx_pec_data(tx_pec_data), .pec_err(pec_err),
        .xfer_done(xfer_done)
    );

    typedef struct packed {
        logic [7:0] n;
        logic       req;
        logic       rl;
        logic       slv;
        logic       sbc;
        logic       rx;
        logic       bad_code;
        logic       slot;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{8'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ 8'h07;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start();
        start_evt = 1'b1;
        step();
        start_evt = 1'b0;
        gcrc = 8'h00;
    endtask

    task automatic send(input logic [7:0] d, input logic addr);
        byte_data = d; byte_is_addr = addr; byte_done = 1'b1;
        step();
        byte_done = 1'b0; byte_is_addr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        gcrc = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pec_next", {7'd0, pec_next}, 8'd0);
        check("R1 pec_err", {7'd0, pec_err}, 8'd0);
        check("R1 xfer_done", {7'd0, xfer_done}, 8'd0);
        check("R1 pec_en", {7'd0, pec_en}, 8'd0);
        check("R1 tx_pec_data", tx_pec_data, 8'h00);
        rst_n = 1'b1;
        step();

        // R2: write accepted while disabled
        cfg_pec_en = 1'b1; cfg_wr = 1'b1; step(); cfg_wr = 1'b0;
        check("R2 write when disabled", {7'd0, pec_en}, 8'd1);
        periph_en = 1'b1; step();
        cfg_pec_en = 1'b0; cfg_wr = 1'b1; step(); cfg_wr = 1'b0;
        check("R2 write ignored when enabled", {7'd0, pec_en}, 8'd1);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            nbytes = VECS[v].n; pec_byte_req = VECS[v].req; reload = VECS[v].rl;
            slave_mode = VECS[v].slv; byte_cnt_en = VECS[v].sbc; dir_rx = VECS[v].rx;
            do_start();
            check("R4 crc cleared at start", tx_pec_data, 8'h00);
            d = 8'hA6 ^ 8'(v);
            send(d, 1'b1);
            gcrc = ref_crc(gcrc, d);
            check("R3 crc after address", tx_pec_data, gcrc);
            check("R9 address not counted", {7'd0, xfer_done}, 8'd0);
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                logic is_slot;
                is_slot = VECS[v].slot && (k == int'(VECS[v].n) - 1);
                check(VECS[v].rl ? "R6 pec_next" : (VECS[v].slv ? "R7 pec_next" : "R5 pec_next"),
                      {7'd0, pec_next}, {7'd0, is_slot});
                if (is_slot && !VECS[v].rx) begin
                    check("R3 tx slot value", tx_pec_data, gcrc);
                    d = gcrc;
                end else if (is_slot) begin
                    d = VECS[v].bad_code ? (gcrc ^ 8'h5A) : gcrc;
                end else begin
                    d = 8'(v * 37 + k * 11 + 1);
                end
                send(d, 1'b0);
                gcrc = ref_crc(gcrc, d);
                check("R8 pec_err", {7'd0, pec_err},
                      {7'd0, is_slot && VECS[v].rx && VECS[v].bad_code});
                check("R9 xfer_done", {7'd0, xfer_done},
                      {7'd0, k == int'(VECS[v].n) - 1});
                check("R3 running crc", tx_pec_data, gcrc);
            end
            check("R5 slot cleared after last", {7'd0, pec_next}, 8'd0);
            step();
            check("R8 err one cycle", {7'd0, pec_err}, 8'd0);
            check("R9 done one cycle", {7'd0, xfer_done}, 8'd0);
        end

        // R4: repeated START mid transfer restarts count
        nbytes = 8'd3; pec_byte_req = 1'b1; reload = 1'b0; slave_mode = 1'b0; dir_rx = 1'b0;
        do_start();
        send(8'h11, 1'b0);
        gcrc = ref_crc(gcrc, 8'h11);
        nbytes = 8'd2;
        do_start();
        check("R4 crc cleared at repeated start", tx_pec_data, 8'h00);
        send(8'h22, 1'b0);
        check("R4 reloaded count gives slot", {7'd0, pec_next}, 8'd1);

        // R10: disable returns to idle, bytes ignored
        periph_en = 1'b0; step();
        check("R10 idle no slot", {7'd0, pec_next}, 8'd0);
        periph_en = 1'b1; step();
        d = tx_pec_data;
        send(8'h3C, 1'b0);
        check("R10 crc unchanged in idle", tx_pec_data, d);
        check("R10 no done in idle", {7'd0, xfer_done}, 8'd0);
        check("R10 no slot in idle", {7'd0, pec_next}, 8'd0);

        // R2: write accepted again after disable
        periph_en = 1'b0; step();
        cfg_pec_en = 1'b0; cfg_wr = 1'b1; step(); cfg_wr = 1'b0;
        check("R2 clear when disabled", {7'd0, pec_en}, 8'd0);
        periph_en = 1'b1; step();
        nbytes = 8'd2; pec_byte_req = 1'b1;
        do_start();
        send(8'h44, 1'b0);
        check("R5 no slot without enable", {7'd0, pec_next}, 8'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule